// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block takes a requested clock rate and a reference clock rate, both in whole MHz, and walks the space of PLL settings to find the input divider M, the feedback multiplier N and the post-divider index PL whose output lands nearest the request. The search runs as a sequence of steps. One iterative divider is shared by every step, and counters for the PL, M and N loops drive it. A caller raises `start_i` for one cycle while the engine is idle. `busy_o` stays high for the whole search. A one-cycle `done_o` pulse then presents the chosen coefficients, the frequency they give and a flag that says no legal setting was found.

The working target is twice the requested rate. A 2% margin is added to it to get the VCO goal, and that goal sets the range of post-divider indices worth trying. Each candidate must keep the reference-to-M ratio inside a comparison window and the VCO inside its legal window. Candidates are ranked by the rounded error of their output against the target.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `no_match_o`, `m_o`, `n_o`, `pl_o` and `freq_o` are all zero.
- R2: A `start_i` seen while idle raises `busy_o` on the next cycle. The search ends with `done_o` high for exactly one cycle, in the same cycle that `busy_o` falls. A `start_i` raised while busy is ignored, and its request and reference values have no effect on the result.
- R3: The target is T = 2·req. The VCO goal is G = T + floor(T/50). The upper VCO limit is 2064, or G when G is larger. The lower VCO limit is 1000.
- R4: The post-divider table maps index 0..14 to divide values 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32. The high bound ceil(upper/G) and the low bound floor(1000/G) are each clamped to 1..32. Each is then turned into the first index among 0..13 whose divide value is at least the bound, or into 14 when no such index exists. Indices are searched from low to high, and `pl_o` carries the 4-bit index.
- R5: For each index, M runs from 1 to 255. An M is used only when floor(ref/M) lies between 12 and 38 inclusive.
- R6: N is tried from floor(T·div·M/ref) up to the ceiling of the same quotient. N values below 8 or above 255 are rejected, and the engine moves to the next M when the floor value is above 255.
- R7: The VCO of a candidate is floor(ref·N/M), and it must lie between the two VCO limits. Its output is floor((VCO + floor(div/2))/div), and its error is the absolute difference between that output and T.
- R8: A candidate replaces the best one only when its error is strictly smaller, so the earliest of two equal candidates is kept. The search stops at once when the error reaches zero.
- R9: When no candidate is accepted, the result is M=255, N=8, PL index 1, and `no_match_o` is 1 in the `done_o` cycle. Otherwise `no_match_o` is 0.
- R10: `freq_o` = floor(ref·N / (M·div(PL))), computed from the final M, N and PL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (honoured only when idle) |
| req_mhz_i | input | REQ_W | Requested rate in MHz |
| ref_mhz_i | input | REQ_W | Reference rate in MHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| m_o | output | M_W | Chosen input divider |
| n_o | output | N_W | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divider index |
| freq_o | output | REQ_W+N_W | Frequency given by the chosen coefficients |
| no_match_o | output | 1 | No legal candidate was found |

## Verification
`busy_o` is due one cycle after the clock edge that samples `start_i`. The bench samples it at the next falling edge. How long a search takes depends on the data, so the bench polls `done_o` at every falling edge and reads the result outputs in the one cycle where it is high. It then checks at the following falling edge that the strobe has gone low. Expected coefficients come from a model of the search written in the bench, which is checked against vectors worked out by hand for the zero-error stop, the raised VCO limit and the no-match fallback.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int PL_W       = 4;
    localparam int PDIV_W     = 6;
    localparam int PL_ENTRIES = 15;

    typedef enum logic [3:0] {
        S_IDLE, S_T50, S_HI, S_LO, S_PLSET, S_MCHK, S_NDIV,
        S_NCHK, S_VCO, S_LWV, S_FIN, S_WFIN
    } state_e;

    // post-divider value for each index; the sequence is not monotonic
    function automatic logic [PDIV_W-1:0] pdiv(input logic [PL_W-1:0] idx);
        case (idx)
            4'd0:  pdiv = 6'd1;
            4'd1:  pdiv = 6'd2;
            4'd2:  pdiv = 6'd3;
            4'd3:  pdiv = 6'd4;
            4'd4:  pdiv = 6'd5;
            4'd5:  pdiv = 6'd6;
            4'd6:  pdiv = 6'd8;
            4'd7:  pdiv = 6'd10;
            4'd8:  pdiv = 6'd12;
            4'd9:  pdiv = 6'd16;
            4'd10: pdiv = 6'd12;
            4'd11: pdiv = 6'd16;
            4'd12: pdiv = 6'd20;
            4'd13: pdiv = 6'd24;
            4'd14: pdiv = 6'd32;
            default: pdiv = 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/pll_div_iter.sv
module pll_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_t;

    div_t d_d, d_q;
    logic [W:0] shifted;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        shifted  = {d_q.rem, d_q.quo[W-1]};
        if (start_i && !d_q.run) begin
            d_d.run = 1'b1;
            d_d.cnt = CW'(W);
            d_d.rem = '0;
            d_d.quo = num_i;
            d_d.den = den_i;
        end else if (d_q.run) begin
            if (shifted >= {1'b0, d_q.den}) begin
                d_d.rem = W'(shifted - {1'b0, d_q.den});
                d_d.quo = {d_q.quo[W-2:0], 1'b1};
            end else begin
                d_d.rem = shifted[W-1:0];
                d_d.quo = {d_q.quo[W-2:0], 1'b0};
            end
            d_d.cnt = d_q.cnt - 1'b1;
            if (d_q.cnt == CW'(1)) begin
                d_d.run  = 1'b0;
                d_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign done_o = d_q.done;
    assign quo_o  = d_q.quo;
    assign rem_o  = d_q.rem;

    // R10
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.done && d_q.den != '0) |-> (d_q.rem < d_q.den));

    // R10
    div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.done |=> !d_q.done);

endmodule

// File: rtl/pll_pdiv_index.sv
module pll_pdiv_index
    import pll_search_pkg::*;
(
    input  logic [PDIV_W-1:0] div_val_i,
    output logic [PL_W-1:0]   idx_o
);
    localparam int SCAN_LAST = PL_ENTRIES - 2;

    // first index below the last entry whose divide value reaches the bound
    always_comb begin
        idx_o = PL_W'(PL_ENTRIES - 1);
        for (int i = SCAN_LAST; i >= 0; i--) begin
            if (pdiv(PL_W'(i)) >= div_val_i) idx_o = PL_W'(i);
        end
    end

    // R4
    idx_range_chk: assert property (@(div_val_i) 1'b1 |-> (idx_o <= PL_W'(PL_ENTRIES - 1)))
        else $error("index out of table");

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int REQ_W    = 12,
    parameter int DW       = 32,
    parameter int M_W      = 8,
    parameter int N_W      = 8,
    parameter int VCO_MIN  = 1000,
    parameter int VCO_MAX  = 2064,
    parameter int U_MIN    = 12,
    parameter int U_MAX    = 38,
    parameter int N_MIN    = 8,
    parameter int DIV_LIM  = 32,
    parameter int MARGIN   = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [REQ_W-1:0]     req_mhz_i,
    input  logic [REQ_W-1:0]     ref_mhz_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [M_W-1:0]       m_o,
    output logic [N_W-1:0]       n_o,
    output logic [PL_W-1:0]      pl_o,
    output logic [REQ_W+N_W-1:0] freq_o,
    output logic                 no_match_o
);
    localparam int OUT_W = REQ_W + N_W;
    localparam int M_MAX = (1 << M_W) - 1;
    localparam int N_MAX = (1 << N_W) - 1;

    typedef struct packed {
        state_e            st;
        logic [REQ_W-1:0]  ref_v;
        logic [DW-1:0]     tgt;
        logic [DW-1:0]     tvco;
        logic [DW-1:0]     vmax;
        logic [DW-1:0]     tvp;
        logic [DW-1:0]     n;
        logic [DW-1:0]     n2;
        logic [M_W-1:0]    m;
        logic [PL_W-1:0]   pl;
        logic [PL_W-1:0]   pl_hi;
        logic [M_W-1:0]    best_m;
        logic [N_W-1:0]    best_n;
        logic [PL_W-1:0]   best_pl;
        logic [DW-1:0]     best_d;
        logic              found;
        logic              dstart;
        logic [DW-1:0]     dnum;
        logic [DW-1:0]     dden;
        logic              busy;
        logic              done;
        logic              no_match;
        logic [M_W-1:0]    m_out;
        logic [N_W-1:0]    n_out;
        logic [PL_W-1:0]   pl_out;
        logic [OUT_W-1:0]  freq;
    } eng_t;

    eng_t r_d, r_q;

    logic              div_done;
    logic [DW-1:0]     div_q, div_r;
    logic [PDIV_W-1:0] bound;
    logic [PL_W-1:0]   bound_idx;
    logic              adv_m;
    logic [DW-1:0]     ref_w, pdv, delta, tv;

    pll_div_iter #(.W(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (r_q.dstart),
        .num_i   (r_q.dnum),
        .den_i   (r_q.dden),
        .done_o  (div_done),
        .quo_o   (div_q),
        .rem_o   (div_r)
    );

    // clamp the quotient to a legal divide value, then map it to an index
    always_comb begin
        if (div_q == '0)                 bound = PDIV_W'(1);
        else if (div_q > DW'(DIV_LIM))   bound = PDIV_W'(DIV_LIM);
        else                             bound = div_q[PDIV_W-1:0];
    end

    pll_pdiv_index u_idx (
        .div_val_i (bound),
        .idx_o     (bound_idx)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.dstart = 1'b0;
        adv_m      = 1'b0;
        ref_w      = DW'(r_q.ref_v);
        pdv        = DW'(pdiv(r_q.pl));
        delta      = (div_q >= r_q.tgt) ? (div_q - r_q.tgt) : (r_q.tgt - div_q);
        tv         = r_q.tgt + div_q;

        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.busy    = 1'b1;
                    r_d.ref_v   = ref_mhz_i;
                    r_d.tgt     = DW'(req_mhz_i) << 1;
                    r_d.best_m  = M_W'(M_MAX);
                    r_d.best_n  = N_W'(N_MIN);
                    r_d.best_pl = PL_W'(1);
                    r_d.best_d  = '1;
                    r_d.found   = 1'b0;
                    r_d.dstart  = 1'b1;
                    r_d.dnum    = DW'(req_mhz_i) << 1;
                    r_d.dden    = DW'(MARGIN);
                    r_d.st      = S_T50;
                end
            end
            S_T50: begin
                if (div_done) begin
                    r_d.tvco   = tv;
                    r_d.vmax   = (tv > DW'(VCO_MAX)) ? tv : DW'(VCO_MAX);
                    r_d.dstart = 1'b1;
                    r_d.dnum   = ((tv > DW'(VCO_MAX)) ? tv : DW'(VCO_MAX)) + tv - 1'b1;
                    r_d.dden   = tv;
                    r_d.st     = S_HI;
                end
            end
            S_HI: begin
                if (div_done) begin
                    r_d.pl_hi  = bound_idx;
                    r_d.dstart = 1'b1;
                    r_d.dnum   = DW'(VCO_MIN);
                    r_d.dden   = r_q.tvco;
                    r_d.st     = S_LO;
                end
            end
            S_LO: begin
                if (div_done) begin
                    r_d.pl = bound_idx;
                    r_d.st = S_PLSET;
                end
            end
            S_PLSET: begin
                r_d.tvp = r_q.tgt * pdv;
                r_d.m   = M_W'(1);
                r_d.st  = S_MCHK;
            end
            S_MCHK: begin
                if ((ref_w < DW'(U_MIN) * DW'(r_q.m)) ||
                    (ref_w >= DW'(U_MAX + 1) * DW'(r_q.m))) begin
                    adv_m = 1'b1;
                end else begin
                    r_d.dstart = 1'b1;
                    r_d.dnum   = r_q.tvp * DW'(r_q.m);
                    r_d.dden   = ref_w;
                    r_d.st     = S_NDIV;
                end
            end
            S_NDIV: begin
                if (div_done) begin
                    if (div_q > DW'(N_MAX)) begin
                        adv_m = 1'b1;
                    end else begin
                        r_d.n  = div_q;
                        r_d.n2 = div_q + DW'(div_r != '0);
                        r_d.st = S_NCHK;
                    end
                end
            end
            S_NCHK: begin
                if (r_q.n > r_q.n2 || r_q.n > DW'(N_MAX)) begin
                    adv_m = 1'b1;
                end else if (r_q.n < DW'(N_MIN)) begin
                    r_d.n = r_q.n + 1'b1;
                end else begin
                    r_d.dstart = 1'b1;
                    r_d.dnum   = ref_w * r_q.n;
                    r_d.dden   = DW'(r_q.m);
                    r_d.st     = S_VCO;
                end
            end
            S_VCO: begin
                if (div_done) begin
                    if (div_q >= DW'(VCO_MIN) && div_q <= r_q.vmax) begin
                        r_d.dstart = 1'b1;
                        r_d.dnum   = div_q + (pdv >> 1);
                        r_d.dden   = pdv;
                        r_d.st     = S_LWV;
                    end else begin
                        r_d.n  = r_q.n + 1'b1;
                        r_d.st = S_NCHK;
                    end
                end
            end
            S_LWV: begin
                if (div_done) begin
                    if (delta < r_q.best_d) begin
                        r_d.best_d  = delta;
                        r_d.best_m  = r_q.m;
                        r_d.best_n  = r_q.n[N_W-1:0];
                        r_d.best_pl = r_q.pl;
                        r_d.found   = 1'b1;
                    end
                    if (delta == '0) begin
                        r_d.st = S_FIN;
                    end else begin
                        r_d.n  = r_q.n + 1'b1;
                        r_d.st = S_NCHK;
                    end
                end
            end
            S_FIN: begin
                r_d.dstart = 1'b1;
                r_d.dnum   = ref_w * DW'(r_q.best_n);
                r_d.dden   = DW'(r_q.best_m) * DW'(pdiv(r_q.best_pl));
                r_d.st     = S_WFIN;
            end
            S_WFIN: begin
                if (div_done) begin
                    r_d.m_out    = r_q.best_m;
                    r_d.n_out    = r_q.best_n;
                    r_d.pl_out   = r_q.best_pl;
                    r_d.freq     = div_q[OUT_W-1:0];
                    r_d.no_match = !r_q.found;
                    r_d.done     = 1'b1;
                    r_d.busy     = 1'b0;
                    r_d.st       = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        // step the M loop, rolling over into the next post-divider index
        if (adv_m) begin
            if (r_q.m == M_W'(M_MAX)) begin
                if (r_q.pl >= r_q.pl_hi) begin
                    r_d.st = S_FIN;
                end else begin
                    r_d.pl = r_q.pl + 1'b1;
                    r_d.st = S_PLSET;
                end
            end else begin
                r_d.m  = r_q.m + 1'b1;
                r_d.st = S_MCHK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign m_o        = r_q.m_out;
    assign n_o        = r_q.n_out;
    assign pl_o       = r_q.pl_out;
    assign freq_o     = r_q.freq;
    assign no_match_o = r_q.no_match;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $fell(busy_o)));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && start_i) |=> busy_o);

    // R9
    nomatch_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && no_match_o) |->
            (m_o == M_W'(M_MAX) && n_o == N_W'(N_MIN) && pl_o == PL_W'(1)));

    // R6
    n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !no_match_o) |-> (n_o >= N_W'(N_MIN)));

    // R5
    m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (m_o != '0));

    // R4
    pl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pl_o <= PL_W'(PL_ENTRIES - 1)));

    // R8
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.st != S_IDLE && $past(busy_o)) |-> (r_q.best_d <= $past(r_q.best_d)));

endmodule

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;
    localparam int REQ_W = 12;
    localparam int M_W   = 8;
    localparam int N_W   = 8;
    localparam int LIMIT = 40000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [REQ_W-1:0]     req_mhz_i = '0;
    logic [REQ_W-1:0]     ref_mhz_i = '0;
    logic                 busy_o, done_o, no_match_o;
    logic [M_W-1:0]       m_o;
    logic [N_W-1:0]       n_o;
    logic [3:0]           pl_o;
    logic [REQ_W+N_W-1:0] freq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pll_coef_search u_pll_coef_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .req_mhz_i  (req_mhz_i),
        .ref_mhz_i  (ref_mhz_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .m_o        (m_o),
        .n_o        (n_o),
        .pl_o       (pl_o),
        .freq_o     (freq_o),
        .no_match_o (no_match_o)
    );

    // hand-worked vectors: req, ref, m, n, pl, freq, no_match
    localparam int HAND_N = 4;
    localparam int HAND [HAND_N][7] = '{
        '{504,  12, 1,   84,  0, 1008, 0},
        '{1100, 12, 1,   183, 0, 2196, 0},
        '{72,   12, 1,   96,  6, 144,  0},
        '{13,   12, 255, 8,   1, 0,    1}
    };

    // further stimulus checked against the bench model
    localparam int MOD_N = 10;
    localparam int MOD [MOD_N][2] = '{
        '{100, 38}, '{333, 27}, '{850, 19}, '{1700, 12}, '{250, 13},
        '{612, 26}, '{36, 38},  '{300, 10}, '{996, 31},  '{540, 20}
    };

    function automatic int tdiv(int i);
        case (i)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; default: return 32;
        endcase
    endfunction

    function automatic int to_idx(int v);
        if (v < 1) v = 1;
        if (v > 32) v = 32;
        for (int i = 0; i < 14; i++) if (tdiv(i) >= v) return i;
        return 14;
    endfunction

    task automatic model(input int req, input int rf, output int om, output int on,
                         output int opl, output int ofr, output int onm);
        int t, g, vmax, lo, hi, bd, vco, lwv, d, nf, nc;
        bit stop;
        t = 2 * req;
        g = t + t / 50;
        vmax = (g > 2064) ? g : 2064;
        hi = to_idx((vmax + g - 1) / g);
        lo = to_idx(1000 / g);
        om = 255; on = 8; opl = 1; onm = 1;
        bd = 32'h7fffffff;
        stop = 0;
        for (int pl = lo; pl <= hi && !stop; pl++) begin
            for (int m = 1; m <= 255 && !stop; m++) begin
                if (rf / m < 12 || rf / m > 38) continue;
                nf = t * tdiv(pl) * m / rf;
                nc = (t * tdiv(pl) * m + rf - 1) / rf;
                if (nf > 255) continue;
                for (int n = nf; n <= nc && !stop; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = rf * n / m;
                    if (vco < 1000 || vco > vmax) continue;
                    lwv = (vco + tdiv(pl) / 2) / tdiv(pl);
                    d = (lwv > t) ? lwv - t : t - lwv;
                    if (d < bd) begin
                        bd = d; om = m; on = n; opl = pl; onm = 0;
                    end
                    if (d == 0) stop = 1;
                end
            end
        end
        ofr = rf * on / (om * tdiv(opl));
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input int req, input int rf, input bit inject,
                       output int rm, output int rn, output int rpl,
                       output int rfr, output int rnm);
        int cyc;
        @(negedge clk);
        start_i = 1'b1; req_mhz_i = REQ_W'(req); ref_mhz_i = REQ_W'(rf);
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "busy after start", int'(busy_o), 1);
        if (inject) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; req_mhz_i = REQ_W'(504); ref_mhz_i = REQ_W'(12);
            @(negedge clk);
            start_i = 1'b0; req_mhz_i = '0; ref_mhz_i = '0;
        end
        cyc = 0;
        while (done_o !== 1'b1 && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        check("R2", "done reached", int'(done_o === 1'b1), 1);
        check("R2", "busy low with done", int'(busy_o), 0);
        rm = int'(m_o); rn = int'(n_o); rpl = int'(pl_o);
        rfr = int'(freq_o); rnm = int'(no_match_o);
        @(negedge clk);
        check("R2", "done one cycle", int'(done_o), 0);
    endtask

    task automatic compare(input string tag, input int am, input int an, input int apl,
                           input int afr, input int anm, input int em, input int en,
                           input int epl, input int efr, input int enm);
        check(tag, "m", am, em);
        check(tag, "n", an, en);
        check(tag, "pl", apl, epl);
        check("R10", "freq", afr, efr);
        check("R9", "no_match", anm, enm);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int am, an, apl, afr, anm, em, en, epl, efr, enm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "no_match", int'(no_match_o), 0);
        check("R1", "m", int'(m_o), 0);
        check("R1", "n", int'(n_o), 0);
        check("R1", "pl", int'(pl_o), 0);
        check("R1", "freq", int'(freq_o), 0);
        rst_n = 1'b1;

        // hand vectors: zero-error stop (R8, R7), raised VCO limit (R3),
        // index range (R4, R5, R6), fallback through the last table entry (R9)
        for (int i = 0; i < HAND_N; i++) begin
            run(HAND[i][0], HAND[i][1], 1'b0, am, an, apl, afr, anm);
            compare("R3 R4 R7 R8", am, an, apl, afr, anm,
                    HAND[i][2], HAND[i][3], HAND[i][4], HAND[i][5], HAND[i][6]);
        end

        // model vectors cover R5, R6 and the strict-improvement rule R8
        for (int i = 0; i < MOD_N; i++) begin
            model(MOD[i][0], MOD[i][1], em, en, epl, efr, enm);
            run(MOD[i][0], MOD[i][1], 1'b0, am, an, apl, afr, anm);
            compare("R5 R6 R8", am, an, apl, afr, anm, em, en, epl, efr, enm);
        end

        // R2: a start pulse while busy changes nothing
        model(100, 38, em, en, epl, efr, enm);
        run(100, 38, 1'b1, am, an, apl, afr, anm);
        compare("R2", am, an, apl, afr, anm, em, en, epl, efr, enm);
        repeat (3) @(negedge clk);
        check("R2", "stays idle after ignored start", int'(busy_o), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule